// File: doc/BRIEF.md
# SDIO Function-0 Direct Register Responder

This block sits on the card side of an SDIO link and answers single-byte direct register commands aimed at the common control area of function 0. Each command arrives as a 32-bit argument together with a valid strobe. The block takes the argument apart into a direction flag, a function number, a read-after-write flag, a 17-bit register address and a data byte. It then reads or updates the addressed register. One cycle later it returns a response byte and an error flag.

The implemented registers are the function enable and function ready pair, the interrupt enable register, the bus control register, the capability byte and the high-speed register. The ready bits are owned by the card. Each one follows its enable bit after a parameterised power-up delay. The capability byte and the high-speed support flag come from parameters and do not change. Command framing, CRC, the physical lines and the register spaces of functions 1 to 7 are handled elsewhere.

Top module: `sdio_cccr_responder`

## Requirements
- R1: `resp_valid` is high in exactly the cycle after each cycle in which `cmd_valid` is high. While `resp_valid` is low, `resp_data` and `resp_err` are zero.
- R2: The argument fields sit at these positions: bit 31 is the write flag, bits 30:28 are the function number, bit 27 is the read-after-write flag, bits 25:9 are the register address and bits 7:0 are the write data. A command whose function number is not 0 sets `resp_err`, returns data 0x00 and changes no register.
- R3: The only implemented addresses are 0x00002, 0x00003, 0x00004, 0x00007, 0x00008 and 0x00013, compared over all 17 address bits. Any other address sets `resp_err`, returns 0x00 and changes no register.
- R4: A read (bit 31 = 0) returns the current contents of the addressed register with `resp_err` low. The data byte of the argument has no effect on a read.
- R5: A write with bit 27 = 0 updates the register and returns 0x00. A write with bit 27 = 1 updates the register and returns the value the register holds after that write.
- R6: Function enable (0x02): bits 7:1 can be read and written. Bit 0 always reads 0.
- R7: Function ready (0x03) is read-only. Its bit N reads 1 once enable bit N has been 1 for READY_DELAY clock edges; a read captured at the k-th edge after the enabling write sees the bit set when k > READY_DELAY. The bit reads 0 from the very next command after a write that clears enable bit N. Bit 0 always reads 0.
- R8: Interrupt enable (0x04): all 8 bits can be read and written. Bit 0 is the master enable and bits 7:1 are the per-function enables.
- R9: Bus control (0x07): bit 7 (card-detect disable) and the width field in bits 1:0 can be written. Bits 6:2 read 0. The width field accepts 00 (1-bit) and 10 (4-bit). A write carrying 01 or 11 leaves the width unchanged but still updates bit 7.
- R10: Capability (0x08) is read-only and always returns the CAP_VALUE parameter. In it, bit 6 flags a low-speed card and bit 7 flags a low-speed card with 4-bit support.
- R11: High speed (0x13): bit 0 reads HS_SUPPORT and is read-only. Bit 1, the high-speed enable, can be written only when HS_SUPPORT is 1 and otherwise reads 0. Bits 7:2 read 0.
- R12: After reset, function enable, function ready, interrupt enable and bus control read 0x00, and bit 1 of the high-speed register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command argument is presented this cycle |
| cmd_arg | input | 32 | Direct-access command argument |
| resp_valid | output | 1 | Response is present this cycle |
| resp_data | output | 8 | Response data byte |
| resp_err | output | 1 | Bad function number or unimplemented address |

## Verification
The main bench instance uses READY_DELAY = 4, HS_SUPPORT = 1 and CAP_VALUE = 0xC5. The short delay lets the bench sweep every idle gap from zero up to one past the delay, so the exact edge at which a ready bit appears is checked. With HS_SUPPORT set, the writable high-speed enable bit can be swept over all 256 data values. A second instance built with HS_SUPPORT = 0 covers the other branch, where the enable bit is locked low. Because the registers are small, every data byte is written to every writable register, and every address from 0x00 to 0x1F is probed for the error flag.

// File: rtl/sdio_cccr_pkg.sv
package sdio_cccr_pkg;

    localparam int ARG_W  = 32;
    localparam int ADDR_W = 17;
    localparam int BYTE_W = 8;
    localparam int FN_W   = 3;
    localparam int FN_CNT = 7;

    localparam logic [ADDR_W-1:0] ADR_FN_EN   = 17'h00002;
    localparam logic [ADDR_W-1:0] ADR_FN_RDY  = 17'h00003;
    localparam logic [ADDR_W-1:0] ADR_IRQ_EN  = 17'h00004;
    localparam logic [ADDR_W-1:0] ADR_BUS_CTL = 17'h00007;
    localparam logic [ADDR_W-1:0] ADR_CAPS    = 17'h00008;
    localparam logic [ADDR_W-1:0] ADR_SPEED   = 17'h00013;

    localparam logic [BYTE_W-1:0] FN_EN_WMASK = 8'hFE;

    typedef struct packed {
        logic              wr;
        logic [FN_W-1:0]   fn;
        logic              raw;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } dcmd_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FN_EN,
        SEL_FN_RDY,
        SEL_IRQ_EN,
        SEL_BUS_CTL,
        SEL_CAPS,
        SEL_SPEED
    } regsel_e;

    function automatic regsel_e addr_to_sel(input logic [ADDR_W-1:0] a);
        regsel_e s;
        case (a)
            ADR_FN_EN:   s = SEL_FN_EN;
            ADR_FN_RDY:  s = SEL_FN_RDY;
            ADR_IRQ_EN:  s = SEL_IRQ_EN;
            ADR_BUS_CTL: s = SEL_BUS_CTL;
            ADR_CAPS:    s = SEL_CAPS;
            ADR_SPEED:   s = SEL_SPEED;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic width_ok(input logic [1:0] w);
        return (w == 2'b00) || (w == 2'b10);
    endfunction

endpackage

// File: rtl/sdio_arg_decode.sv
module sdio_arg_decode
    import sdio_cccr_pkg::*;
(
    input  logic [ARG_W-1:0] arg,
    output dcmd_t            cmd,
    output regsel_e          sel,
    output logic             hit
);

    logic unused_arg_bits;

    always_comb begin
        cmd.wr    = arg[31];
        cmd.fn    = arg[30:28];
        cmd.raw   = arg[27];
        cmd.addr  = arg[25:9];
        cmd.wdata = arg[7:0];
    end

    assign unused_arg_bits = ^{arg[26], arg[8]};
    assign sel = addr_to_sel(cmd.addr);
    assign hit = (cmd.fn == '0) && (sel != SEL_NONE);

endmodule

// File: rtl/sdio_ready_timer.sv
module sdio_ready_timer #(
    parameter int DELAY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic rdy
);

    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else if (!rdy) begin
            if (cnt == LAST) begin
                rdy <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdio_reg_bank.sv
module sdio_reg_bank
    import sdio_cccr_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CAP_VALUE  = 8'h13,
    parameter bit                HS_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  dcmd_t             cmd,
    input  regsel_e           sel,
    input  logic              hit,
    input  logic [BYTE_W-1:0] rdy_vec,
    output logic [BYTE_W-1:0] fn_en_q,
    output logic [BYTE_W-1:0] irq_en_q,
    output logic [BYTE_W-1:0] bus_q,
    output logic [BYTE_W-1:0] speed_q,
    output logic [BYTE_W-1:0] rd_before,
    output logic [BYTE_W-1:0] rd_after
);

    localparam logic [BYTE_W-1:0] SPEED_RST = {{(BYTE_W-1){1'b0}}, HS_SUPPORT};

    logic              wr_fire;
    logic [BYTE_W-1:0] fn_en_nx, irq_en_nx, bus_nx, speed_nx;

    function automatic logic [BYTE_W-1:0] view(
        input regsel_e           s,
        input logic [BYTE_W-1:0] en_v,
        input logic [BYTE_W-1:0] ie_v,
        input logic [BYTE_W-1:0] bus_v,
        input logic [BYTE_W-1:0] hs_v,
        input logic [BYTE_W-1:0] rdy_v
    );
        logic [BYTE_W-1:0] v;
        case (s)
            SEL_FN_EN:   v = en_v;
            SEL_FN_RDY:  v = rdy_v;
            SEL_IRQ_EN:  v = ie_v;
            SEL_BUS_CTL: v = bus_v;
            SEL_CAPS:    v = CAP_VALUE;
            SEL_SPEED:   v = hs_v;
            default:     v = '0;
        endcase
        return v;
    endfunction

    assign wr_fire = acc_valid && hit && cmd.wr;

    always_comb begin
        fn_en_nx  = fn_en_q;
        irq_en_nx = irq_en_q;
        bus_nx    = bus_q;
        speed_nx  = speed_q;
        if (wr_fire) begin
            case (sel)
                SEL_FN_EN:  fn_en_nx  = cmd.wdata & FN_EN_WMASK;
                SEL_IRQ_EN: irq_en_nx = cmd.wdata;
                SEL_BUS_CTL: begin
                    bus_nx      = '0;
                    bus_nx[7]   = cmd.wdata[7];
                    bus_nx[1:0] = width_ok(cmd.wdata[1:0]) ? cmd.wdata[1:0] : bus_q[1:0];
                end
                SEL_SPEED: begin
                    speed_nx    = SPEED_RST;
                    speed_nx[1] = HS_SUPPORT ? cmd.wdata[1] : 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fn_en_q  <= '0;
            irq_en_q <= '0;
            bus_q    <= '0;
            speed_q  <= SPEED_RST;
        end else begin
            fn_en_q  <= fn_en_nx;
            irq_en_q <= irq_en_nx;
            bus_q    <= bus_nx;
            speed_q  <= speed_nx;
        end
    end

    assign rd_before = view(sel, fn_en_q, irq_en_q, bus_q, speed_q, rdy_vec);
    assign rd_after  = view(sel, fn_en_nx, irq_en_nx, bus_nx, speed_nx, rdy_vec);

endmodule

// File: rtl/sdio_cccr_responder.sv
module sdio_cccr_responder
    import sdio_cccr_pkg::*;
#(
    parameter int                READY_DELAY = 16,
    parameter logic [BYTE_W-1:0] CAP_VALUE   = 8'h13,
    parameter bit                HS_SUPPORT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ARG_W-1:0]  cmd_arg,
    output logic              resp_valid,
    output logic [BYTE_W-1:0] resp_data,
    output logic              resp_err
);

    dcmd_t             cmd;
    regsel_e           sel;
    logic              hit;
    logic [BYTE_W-1:0] fn_en_q, irq_en_q, bus_q, speed_q;
    logic [BYTE_W-1:0] rd_before, rd_after;
    logic [BYTE_W-1:0] rdy_raw, rdy_vec;

    sdio_arg_decode u_dec (
        .arg (cmd_arg),
        .cmd (cmd),
        .sel (sel),
        .hit (hit)
    );

    assign rdy_raw[0] = 1'b0;

    for (genvar g = 1; g <= FN_CNT; g++) begin : g_fn_timer
        sdio_ready_timer #(.DELAY(READY_DELAY)) u_tmr (
            .clk (clk),
            .rst (rst),
            .en  (fn_en_q[g]),
            .rdy (rdy_raw[g])
        );
    end

    assign rdy_vec = rdy_raw & fn_en_q;

    sdio_reg_bank #(
        .CAP_VALUE  (CAP_VALUE),
        .HS_SUPPORT (HS_SUPPORT)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (cmd_valid),
        .cmd       (cmd),
        .sel       (sel),
        .hit       (hit),
        .rdy_vec   (rdy_vec),
        .fn_en_q   (fn_en_q),
        .irq_en_q  (irq_en_q),
        .bus_q     (bus_q),
        .speed_q   (speed_q),
        .rd_before (rd_before),
        .rd_after  (rd_after)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_data  <= '0;
            resp_err   <= 1'b0;
        end else begin
            resp_valid <= cmd_valid;
            resp_data  <= '0;
            resp_err   <= 1'b0;
            if (cmd_valid) begin
                if (!hit) begin
                    resp_err <= 1'b1;
                end else if (!cmd.wr) begin
                    resp_data <= rd_before;
                end else if (cmd.raw) begin
                    resp_data <= rd_after;
                end
            end
        end
    end

endmodule

// File: rtl/sdio_cccr_checks.sv
module sdio_cccr_checks #(
    parameter bit HS_SUPPORT = 1'b1
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       resp_valid,
    input logic [7:0] resp_data,
    input logic       resp_err,
    input logic [7:0] fn_en_q,
    input logic [7:0] irq_en_q,
    input logic [7:0] bus_q,
    input logic [7:0] speed_q,
    input logic [7:0] rdy_vec
);

    p_resp_next_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> resp_valid);

    p_resp_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!resp_valid && resp_data == 8'h00 && !resp_err));

    p_err_zero_data_r3: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_valid && resp_data == 8'h00));

    p_err_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_err) |->
            (fn_en_q == $past(fn_en_q) && irq_en_q == $past(irq_en_q) &&
             bus_q == $past(bus_q) && speed_q == $past(speed_q)));

    p_width_legal_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_q[1:0] == 2'b00 || bus_q[1:0] == 2'b10) && bus_q[6:2] == 5'd0);

    p_ready_after_enable_r7: assert property (@(posedge clk) disable iff (rst)
        ((rdy_vec & ~$past(rdy_vec)) & ~$past(fn_en_q)) == 8'h00);

    p_speed_bits_r11: assert property (@(posedge clk) disable iff (rst)
        speed_q[7:2] == 6'd0 && speed_q[0] == HS_SUPPORT && (HS_SUPPORT || !speed_q[1]));

endmodule

bind sdio_cccr_responder sdio_cccr_checks #(.HS_SUPPORT(HS_SUPPORT)) u_checks (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .resp_err   (resp_err),
    .fn_en_q    (fn_en_q),
    .irq_en_q   (irq_en_q),
    .bus_q      (bus_q),
    .speed_q    (speed_q),
    .rdy_vec    (rdy_vec)
);

// File: tb/test_sdio_cccr_responder.sv
module test_sdio_cccr_responder;

    localparam int         D   = 4;
    localparam logic [7:0] CAP = 8'hC5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_arg = '0;
    logic        resp_valid, resp_err;
    logic [7:0]  resp_data;
    logic        c2_valid = 1'b0;
    logic [31:0] c2_arg = '0;
    logic        r2_valid, r2_err;
    logic [7:0]  r2_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic       s_valid, s_err;
    logic [7:0] s_data;
    logic [7:0] m_en, m_ie, m_bus;
    logic       m_hs;

    always #4 clk = ~clk;

    sdio_cccr_responder #(.READY_DELAY(D), .CAP_VALUE(CAP), .HS_SUPPORT(1'b1)) i_sdio_cccr_responder (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_arg(cmd_arg),
        .resp_valid(resp_valid), .resp_data(resp_data), .resp_err(resp_err));

    sdio_cccr_responder #(.READY_DELAY(D), .CAP_VALUE(CAP), .HS_SUPPORT(1'b0)) i_sdio_cccr_responder_nohs (
        .clk(clk), .rst(rst), .cmd_valid(c2_valid), .cmd_arg(c2_arg),
        .resp_valid(r2_valid), .resp_data(r2_data), .resp_err(r2_err));

    function automatic logic [31:0] mk(input bit wr, input int fn, input bit raw,
                                       input int addr, input int d);
        logic [31:0] a;
        a = '0;
        a[31]    = wr;
        a[30:28] = fn[2:0];
        a[27]    = raw;
        a[25:9]  = addr[16:0];
        a[7:0]   = d[7:0];
        return a;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] a);
        cmd_valid = 1'b1;
        cmd_arg   = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        s_valid   = resp_valid;
        s_err     = resp_err;
        s_data    = resp_data;
    endtask

    task automatic rd_chk(input string req, input int addr, input int exp);
        xfer(mk(0, 0, 0, addr, 0));
        chk({req, " valid"}, s_valid, 1);
        chk({req, " err"}, s_err, 0);
        chk({req, " data"}, s_data, exp);
    endtask

    function automatic logic [7:0] bus_model(input logic [7:0] old, input logic [7:0] d);
        logic [7:0] v;
        v = '0;
        v[7] = d[7];
        v[1:0] = (d[1:0] == 2'b00 || d[1:0] == 2'b10) ? d[1:0] : old[1:0];
        return v;
    endfunction

    function automatic logic [7:0] exp_read(input int a);
        case (a)
            2:       return m_en;
            3:       return 8'h00;
            4:       return m_ie;
            7:       return m_bus;
            8:       return CAP;
            'h13:    return {6'd0, m_hs, 1'b1};
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_ie = 0; m_bus = 0; m_hs = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: idle produces no response
        chk("R1 idle valid", resp_valid, 0);
        chk("R1 idle data", resp_data, 0);

        // R12: reset contents
        rd_chk("R12 fn_en", 2, 0);
        rd_chk("R12 fn_rdy", 3, 0);
        rd_chk("R12 irq_en", 4, 0);
        rd_chk("R12 bus", 7, 0);
        rd_chk("R12 speed", 'h13, 8'h01);

        // R3 / R4: address sweep on function 0
        for (int a = 0; a < 32; a++) begin
            bit impl;
            impl = (a == 2 || a == 3 || a == 4 || a == 7 || a == 8 || a == 'h13);
            xfer(mk(0, 0, 0, a, 8'hA5));
            chk("R3 sweep valid", s_valid, 1);
            chk("R3 sweep err", s_err, impl ? 0 : 1);
            chk("R4 sweep data", s_data, impl ? exp_read(a) : 0);
        end
        xfer(mk(1, 0, 1, 'h10004, 8'h3C));
        chk("R3 high addr err", s_err, 1);
        chk("R3 high addr data", s_data, 0);
        rd_chk("R3 high addr no write", 4, 0);

        // R2: non-zero function numbers rejected
        for (int f = 1; f < 8; f++) begin
            xfer(mk(1, f, 1, 4, 8'hFF));
            chk("R2 fn err", s_err, 1);
            chk("R2 fn data", s_data, 0);
        end
        rd_chk("R2 no write", 4, 0);

        // R8: interrupt enable sweep
        for (int d = 0; d < 256; d++) begin
            xfer(mk(1, 0, 1, 4, d));
            chk("R8 irq raw", s_data, d);
            m_ie = d[7:0];
        end
        rd_chk("R8 irq read", 4, m_ie);

        // R9: bus control sweep
        for (int d = 0; d < 256; d++) begin
            m_bus = bus_model(m_bus, d[7:0]);
            xfer(mk(1, 0, 1, 7, d));
            chk("R9 bus raw", s_data, m_bus);
        end
        xfer(mk(1, 0, 1, 7, 8'h02));
        m_bus = 8'h02;
        xfer(mk(1, 0, 1, 7, 8'h83));
        chk("R9 illegal width kept, bit7 set", s_data, 8'h82);
        m_bus = 8'h82;
        xfer(mk(1, 0, 1, 7, 8'h01));
        chk("R9 illegal width kept, bit7 clear", s_data, 8'h02);
        m_bus = 8'h02;
        rd_chk("R9 bus read", 7, m_bus);

        // R11: high-speed enable sweep
        for (int d = 0; d < 256; d++) begin
            xfer(mk(1, 0, 1, 'h13, d));
            chk("R11 speed raw", s_data, {6'd0, d[1], 1'b1});
            m_hs = d[1];
        end

        // R10 / R7: read-only registers ignore writes
        for (int d = 0; d < 256; d += 17) begin
            xfer(mk(1, 0, 1, 8, d));
            chk("R10 caps raw", s_data, CAP);
            xfer(mk(1, 0, 1, 3, d));
            chk("R7 ready ro", s_data, 0);
        end
        rd_chk("R10 caps read", 8, CAP);

        // R6: function enable sweep
        for (int d = 0; d < 256; d++) begin
            xfer(mk(1, 0, 1, 2, d));
            chk("R6 fn_en raw", s_data, d & 8'hFE);
        end
        xfer(mk(1, 0, 1, 2, 0));
        m_en = 0;

        // R5: plain write returns zero, R4 data byte ignored on read
        xfer(mk(1, 0, 0, 4, 8'h5A));
        chk("R5 plain write data", s_data, 0);
        chk("R5 plain write err", s_err, 0);
        xfer(mk(0, 0, 0, 4, 8'hFF));
        chk("R4 read ignores data", s_data, 8'h5A);
        m_ie = 8'h5A;

        // R7: ready timing sweep
        foreach (m_en[i]) begin end
        for (int pass = 0; pass < 2; pass++) begin
            logic [7:0] msk;
            msk = (pass == 0) ? 8'hFE : 8'h0A;
            for (int n = 0; n <= D + 1; n++) begin
                xfer(mk(1, 0, 0, 2, 0));
                xfer(mk(1, 0, 0, 2, msk));
                repeat (n) @(negedge clk);
                xfer(mk(0, 0, 0, 3, 0));
                chk("R7 ready timing", s_data, (n >= D) ? msk : 8'h00);
            end
        end

        // R7: immediate clear on disable
        xfer(mk(1, 0, 0, 2, 8'hFE));
        repeat (D + 2) @(negedge clk);
        rd_chk("R7 all ready", 3, 8'hFE);
        xfer(mk(1, 0, 1, 2, 8'h02));
        chk("R7 partial disable raw", s_data, 8'h02);
        xfer(mk(0, 0, 0, 3, 0));
        chk("R7 ready clears at once", s_data, 8'h02);
        xfer(mk(1, 0, 0, 2, 8'h00));
        xfer(mk(0, 0, 0, 3, 0));
        chk("R7 ready all cleared", s_data, 8'h00);

        // R1: response drops after the last command
        chk("R1 last valid", s_valid, 1);
        @(negedge clk);
        chk("R1 drop valid", resp_valid, 0);
        chk("R1 drop err", resp_err, 0);

        // R11: instance without high-speed support
        c2_valid = 1'b1;
        c2_arg   = mk(1, 0, 1, 'h13, 8'hFF);
        @(negedge clk);
        c2_valid = 1'b0;
        chk("R11 nohs raw", r2_data, 8'h00);
        chk("R11 nohs valid", r2_valid, 1);
        c2_valid = 1'b1;
        c2_arg   = mk(0, 0, 0, 'h13, 0);
        @(negedge clk);
        c2_valid = 1'b0;
        chk("R11 nohs read", r2_data, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule